// File: doc/BRIEF.md
# Threshold-Triggered Acquisition Timer

This block watches a stream of sampled measurement codes (for example current or voltage readings from a converter) and runs one acquisition test each time it is armed. Every test waits for a start trigger. A trigger is a threshold crossing in a programmed direction. In time mode the block then counts microsecond ticks until a separate stop trigger fires, and reports that count. In amplitude mode it waits a programmed number of microseconds after the start trigger and reports the sample value present at that moment.

A prescaler divides the clock by `TICK_DIV` to make the microsecond tick. The prescaler restarts on the start trigger, so the tick phase is fixed relative to the start. In time mode a programmable limit ends a test whose stop trigger never comes. In that case the timeout flag is raised and no result is given. The configuration inputs must stay stable while a test is running.

Top module: `thresh_acq_timer`

## Requirements
- R1: After reset the block is idle, with `done`, `timed_out` and `result` all at 0. No trigger is evaluated until an arm pulse arrives.
- R2: A rising trigger (slope bit 1) fires on a valid sample that is at or above the threshold when the previous valid sample was strictly below it.
- R3: A falling trigger (slope bit 0) fires on a valid sample that is at or below the threshold when the previous valid sample was strictly above it.
- R4: A sample that only sits beyond the threshold, or that crosses it in the wrong direction, fires no trigger. Cycles with `samp_valid` low are ignored: they neither fire a trigger nor replace the previous sample.
- R5: In time mode (`cfg_mode` = 0), let the stop trigger sample be taken N clock edges after the start trigger sample. Then `result` = floor(N / TICK_DIV), and `done` rises on the edge that takes the stop sample.
- R6: In amplitude mode (`cfg_mode` = 1), with `cfg_delay` = D > 0, the block captures the valid sample taken D·TICK_DIV edges after the start trigger sample into `result`, and sets `done` on that edge.
- R7: In amplitude mode with `cfg_delay` = 0, the start trigger sample itself is captured and `done` rises on the same edge.
- R8: In time mode with `cfg_timeout` = L > 0 and no stop trigger, `timed_out` and `done` rise L·TICK_DIV edges after the start trigger, with `result` = 0. A stop trigger on that same edge takes precedence and reports L. L = 0 disables the timeout.
- R9: Once `done` is high, `done`, `timed_out` and `result` hold their values until the next arm pulse. Further triggers have no effect.
- R10: An arm pulse in any state clears `done`, `timed_out` and `result` on the next edge and waits for a fresh start trigger. This abandons any test in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | One-cycle pulse that starts a new test |
| cfg_mode | input | 1 | 0 = time test, 1 = amplitude test |
| cfg_start_thr | input | DATA_W | Start trigger threshold |
| cfg_start_rise | input | 1 | Start slope: 1 rising, 0 falling |
| cfg_stop_thr | input | DATA_W | Stop trigger threshold |
| cfg_stop_rise | input | 1 | Stop slope: 1 rising, 0 falling |
| cfg_delay | input | CNT_W | Amplitude delay in ticks |
| cfg_timeout | input | CNT_W | Time-mode timeout in ticks, 0 = off |
| samp_valid | input | 1 | Sample strobe |
| samp_data | input | DATA_W | Sample code (unsigned) |
| done | output | 1 | Test finished |
| timed_out | output | 1 | Test ended by timeout |
| result | output | max(DATA_W,CNT_W) | Tick count or captured sample |

## Verification
Every result is due on the clock edge that takes a particular sample. For the stop trigger and for delay 0, that is the edge taking the trigger sample itself. For an amplitude capture it is the edge D·TICK_DIV after the start sample, and for a timeout it is L·TICK_DIV edges after. No extra register stage is added. The bench drives each sample at a falling edge and counts the samples it has issued since the start trigger. It reads the outputs at the falling edge that follows the due edge. It also reads them one edge earlier, to show that nothing changed too soon.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_START,
    ST_WAIT_STOP,
    ST_WAIT_DELAY,
    ST_DONE
  } acq_state_e;

  localparam logic MODE_TIME = 1'b0;
  localparam logic MODE_AMPL = 1'b1;

  function automatic int wmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Directional crossing: rising needs prev < thr <= cur, falling needs prev > thr >= cur.
  function automatic logic crossing(input logic [31:0] prev, input logic [31:0] cur,
                                    input logic [31:0] thr, input logic rise);
    if (rise) return (prev < thr) && (cur >= thr);
    else      return (prev > thr) && (cur <= thr);
  endfunction

endpackage

// File: rtl/acq_tick.sv
module acq_tick #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (restart || cnt == PW'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + PW'(1);
      end
      assign tick = !restart && (cnt == PW'(DIV - 1));
    end else begin : g_pass
      assign tick = !restart;
    end
  endgenerate
endmodule

// File: rtl/acq_edge.sv
module acq_edge
  import acq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NTRIG  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        samp_valid,
  input  logic [DATA_W-1:0]           samp_data,
  input  logic [NTRIG-1:0][DATA_W-1:0] thr,
  input  logic [NTRIG-1:0]            rise,
  output logic [NTRIG-1:0]            hit,
  output logic [DATA_W-1:0]           cur_val
);
  logic [DATA_W-1:0] prev_q;
  logic              have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      have_prev <= 1'b0;
    end else if (samp_valid) begin
      prev_q    <= samp_data;
      have_prev <= 1'b1;
    end
  end

  assign cur_val = samp_valid ? samp_data : prev_q;

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    assign hit[i] = samp_valid && have_prev &&
                    crossing(32'(prev_q), 32'(samp_data), 32'(thr[i]), rise[i]);
  end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16,
  parameter int RES_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              mode,
  input  logic [CNT_W-1:0]  delay,
  input  logic [CNT_W-1:0]  tmo_lim,
  input  logic              start_hit,
  input  logic              stop_hit,
  input  logic              tick,
  input  logic [DATA_W-1:0] cur_val,
  output acq_state_e        state,
  output logic              restart,
  output logic [RES_W-1:0]  result,
  output logic              timed_out
);
  logic [CNT_W-1:0] elapsed;

  function automatic logic last_tick(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] lim);
    return (lim != '0) && ((cnt + CNT_W'(1)) == lim);
  endfunction

  assign restart = !arm && (state == ST_WAIT_START) && start_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      elapsed   <= '0;
      result    <= '0;
      timed_out <= 1'b0;
    end else if (arm) begin
      state     <= ST_WAIT_START;
      elapsed   <= '0;
      result    <= '0;
      timed_out <= 1'b0;
    end else begin
      case (state)
        ST_WAIT_START: if (start_hit) begin
          elapsed <= '0;
          if (mode == MODE_AMPL && delay == '0) begin
            result <= RES_W'(cur_val);
            state  <= ST_DONE;
          end else begin
            state <= (mode == MODE_AMPL) ? ST_WAIT_DELAY : ST_WAIT_STOP;
          end
        end
        ST_WAIT_STOP: begin
          if (stop_hit) begin
            result <= RES_W'(elapsed) + RES_W'(tick);
            state  <= ST_DONE;
          end else if (tick) begin
            if (last_tick(elapsed, tmo_lim)) begin
              timed_out <= 1'b1;
              state     <= ST_DONE;
            end else begin
              elapsed <= elapsed + CNT_W'(1);
            end
          end
        end
        ST_WAIT_DELAY: if (tick) begin
          if (last_tick(elapsed, delay)) begin
            result <= RES_W'(cur_val);
            state  <= ST_DONE;
          end else begin
            elapsed <= elapsed + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/thresh_acq_timer.sv
module thresh_acq_timer
  import acq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 125,
  localparam int RES_W   = acq_pkg::wmax(DATA_W, CNT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              cfg_mode,
  input  logic [DATA_W-1:0] cfg_start_thr,
  input  logic              cfg_start_rise,
  input  logic [DATA_W-1:0] cfg_stop_thr,
  input  logic              cfg_stop_rise,
  input  logic [CNT_W-1:0]  cfg_delay,
  input  logic [CNT_W-1:0]  cfg_timeout,
  input  logic              samp_valid,
  input  logic [DATA_W-1:0] samp_data,
  output logic              done,
  output logic              timed_out,
  output logic [RES_W-1:0]  result
);
  logic [1:0]        hits;
  logic              start_hit, stop_hit, tick, restart;
  logic [DATA_W-1:0] cur_val;
  acq_state_e        state;

  acq_edge #(.DATA_W(DATA_W), .NTRIG(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_data(samp_data),
    .thr({cfg_stop_thr, cfg_start_thr}), .rise({cfg_stop_rise, cfg_start_rise}),
    .hit(hits), .cur_val(cur_val)
  );
  assign start_hit = hits[0];
  assign stop_hit  = hits[1];

  acq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  acq_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mode(cfg_mode), .delay(cfg_delay),
    .tmo_lim(cfg_timeout), .start_hit(start_hit), .stop_hit(stop_hit), .tick(tick),
    .cur_val(cur_val), .state(state), .restart(restart), .result(result),
    .timed_out(timed_out)
  );

  assign done = (state == ST_DONE);
endmodule

// File: rtl/thresh_acq_timer_chk.sv
module thresh_acq_timer_chk #(
  parameter int TICK_DIV = 125,
  parameter int RES_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             samp_valid,
  input logic             start_hit,
  input logic             stop_hit,
  input logic             tick,
  input logic             done,
  input logic             timed_out,
  input logic [RES_W-1:0] result
);
  // R1
  idle_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !done && !timed_out && result == '0);
  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit || stop_hit) |-> samp_valid);
  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV > 1) && tick |=> !tick);
  // R8
  timeout_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> done && result == '0);
  // R9
  hold_until_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !arm |=> done && $stable(result) && $stable(timed_out));
  // R10
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !done && !timed_out && result == '0);
endmodule

bind thresh_acq_timer thresh_acq_timer_chk #(.TICK_DIV(TICK_DIV), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .samp_valid(samp_valid),
  .start_hit(start_hit), .stop_hit(stop_hit), .tick(tick),
  .done(done), .timed_out(timed_out), .result(result)
);

// File: tb/thresh_acq_timer_test.sv
module thresh_acq_timer_test;
  localparam int DW = 12, CW = 16, DIV = 10, RW = 16;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic cfg_mode = 1'b0, cfg_start_rise = 1'b1, cfg_stop_rise = 1'b1;
  logic [DW-1:0] cfg_start_thr = 12'd100, cfg_stop_thr = 12'd200;
  logic [CW-1:0] cfg_delay = '0, cfg_timeout = '0;
  logic samp_valid = 1'b0;
  logic [DW-1:0] samp_data = '0;
  logic done, timed_out;
  logic [RW-1:0] result;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  thresh_acq_timer #(.DATA_W(DW), .CNT_W(CW), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_mode(cfg_mode),
    .cfg_start_thr(cfg_start_thr), .cfg_start_rise(cfg_start_rise),
    .cfg_stop_thr(cfg_stop_thr), .cfg_stop_rise(cfg_stop_rise),
    .cfg_delay(cfg_delay), .cfg_timeout(cfg_timeout),
    .samp_valid(samp_valid), .samp_data(samp_data),
    .done(done), .timed_out(timed_out), .result(result)
  );

  task automatic see(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int v, input bit vld = 1'b1);
    @(negedge clk);
    samp_valid = vld; samp_data = DW'(v); arm = 1'b0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic cfg(input logic m, input int st, input logic sr, input int sp,
                     input logic pr, input int dly, input int tmo);
    cfg_mode = m; cfg_start_thr = DW'(st); cfg_start_rise = sr;
    cfg_stop_thr = DW'(sp); cfg_stop_rise = pr;
    cfg_delay = CW'(dly); cfg_timeout = CW'(tmo);
  endtask

  task automatic t_reset();
    @(negedge clk);
    see("R1 done", done, 0); see("R1 timed_out", timed_out, 0); see("R1 result", result, 0);
  endtask

  task automatic t_time_rise();  // R2 R5
    cfg(0, 100, 1, 200, 1, 0, 0);
    put(50); do_arm(); see("R10 cleared", done, 0);
    put(150);
    repeat (36) put(150);
    see("R5 not early", done, 0);
    put(250);
    @(negedge clk);
    see("R2 R5 done", done, 1); see("R5 result N=37", result, 3); see("R5 no tmo", timed_out, 0);
  endtask

  task automatic t_level_only();  // R4 R3
    cfg(0, 100, 1, 80, 0, 0, 0);
    put(150); do_arm();
    repeat (20) put(150);
    put(50);  // falling through a rising threshold: no start
    see("R4 no level trigger", done, 0);
    put(150); // start
    for (int k = 1; k < 40; k++) begin
      if (k == 20) put(70, 1'b0); // invalid crossing sample is ignored
      else put(150);
    end
    put(70);  // falling stop, N=40
    @(negedge clk);
    see("R4 R3 done", done, 1); see("R4 result N=40", result, 4);
  endtask

  task automatic t_fall_start();  // R3
    cfg(0, 100, 0, 300, 1, 0, 0);
    put(200); do_arm();
    put(100); // at-or-below with prev above
    repeat (11) put(100);
    put(300); // at-or-above with prev below, N=12
    @(negedge clk);
    see("R3 done", done, 1); see("R3 result N=12", result, 1);
  endtask

  task automatic t_ampl();  // R6 R9
    cfg(1, 100, 1, 0, 1, 4, 0);
    put(50); do_arm(); put(150);
    for (int k = 1; k < 40; k++) put(150 + k);
    @(negedge clk);
    see("R6 not early", done, 0);
    samp_data = DW'(190);
    @(negedge clk);
    see("R6 done", done, 1); see("R6 captured", result, 190);
    put(50); put(500); put(60); put(700);
    repeat (20) put(700);
    see("R9 done held", done, 1); see("R9 result held", result, 190);
  endtask

  task automatic t_delay0();  // R7
    cfg(1, 100, 1, 0, 1, 0, 0);
    put(50); do_arm(); put(123);
    @(negedge clk);
    see("R7 done", done, 1); see("R7 captured start", result, 123);
  endtask

  task automatic t_timeout();  // R8
    cfg(0, 100, 1, 200, 1, 0, 5);
    put(50); do_arm(); put(150);
    repeat (48) put(150);
    @(negedge clk); see("R8 early 48", timed_out, 0);
    @(negedge clk); see("R8 early 49", timed_out, 0);
    @(negedge clk);
    see("R8 timed_out", timed_out, 1); see("R8 done", done, 1); see("R8 no result", result, 0);
    do_arm();
    see("R10 tmo cleared", timed_out, 0); see("R10 result cleared", result, 0);
    put(50); put(150);
    repeat (49) put(150);
    put(250); // stop on the timeout edge
    @(negedge clk);
    see("R8 stop wins", timed_out, 0); see("R8 stop result", result, 5);
  endtask

  task automatic t_tmo_off();  // R8
    cfg(0, 100, 1, 200, 1, 0, 0);
    put(50); do_arm(); put(150);
    repeat (122) put(150);
    see("R8 zero limit no tmo", timed_out, 0);
    put(250);
    @(negedge clk);
    see("R8 zero limit result", result, 12);
  endtask

  task automatic t_rearm_mid();  // R10
    cfg(0, 100, 1, 200, 1, 0, 0);
    put(50); do_arm(); put(150);
    repeat (5) put(150);
    do_arm();
    put(50); put(150); // fresh start
    repeat (19) put(150);
    put(250);
    @(negedge clk);
    see("R10 restart result", result, 2); see("R10 restart done", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_time_rise();
    t_level_only();
    t_fall_start();
    t_ampl();
    t_delay0();
    t_timeout();
    t_tmo_off();
    t_rearm_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule